// File: doc/BRIEF.md
# Connection Memory Block Initializer

This block fills every word of a time-slot connection memory with one value, so that software does not have to write each word. Host software arms it through two control-register bits. One bit permits block filling, and a second bit starts a fill. A third field, three bits wide, supplies the fill value. Once armed, the block waits for the next frame-boundary strobe. It then walks the memory from address zero upward and writes one word per clock. Each word carries the pattern in its top three bits and zeros in every lower bit. When the last word is written, the block pulses a clear request back to the control register, so the start bit falls without host action.

The block sits between the host's register/memory access path and the connection memory's single write port. While it is not busy, host writes pass straight through. From arming until completion, host writes are held off and a busy flag is raised. If the start bit is set while filling is not permitted, the block writes nothing and requests a clear on the following cycle.

The control is one state machine with five states. IDLE waits for the start bit. REJECT is a one-cycle refusal. WAIT_FRAME holds until a boundary. SWEEP writes the memory. FINISH is a one-cycle completion. The transitions are named as follows:
- arm: IDLE to WAIT_FRAME, when the start bit is set with the enable high.
- refuse: IDLE to REJECT, when the start bit is set with the enable low.
- abort: WAIT_FRAME to REJECT, when the enable falls.
- launch: WAIT_FRAME to SWEEP, on a frame strobe.
- last_word: SWEEP to FINISH, after the top address.
- retire: REJECT or FINISH back to IDLE, unconditionally.

Top module: `cm_block_init`

## Requirements
- R1: After reset, fill_busy, fill_done, trig_clear and cm_we are all low.
- R2: With ctl_blk_en high, ctl_blk_go sampled high in IDLE raises fill_busy from the next cycle. No memory write occurs until a frame_sync is sampled.
- R3: The cycle after the first sampled frame_sync, the sweep writes addresses 0 to 2**ADDR_W-1. It writes one address per cycle, in ascending order, with cm_we high throughout.
- R4: Every sweep word has bits 15..13 equal to ctl_pattern as sampled with the launching frame_sync, and bits 12..0 equal to zero. Later pattern changes have no effect on that sweep.
- R5: The cycle after the last write, trig_clear and fill_done are high for exactly one cycle. fill_busy then falls. A fill occupies 2**ADDR_W+1 cycles after the boundary, which must not exceed 2*FRAME_CYCLES, so a fill completes within two frames.
- R6: If ctl_blk_go is sampled high while ctl_blk_en is low, no write occurs and fill_busy stays low. trig_clear pulses for exactly one cycle in the next cycle.
- R7: While fill_busy is low, cm_we, cm_addr and cm_wdata follow host_we, host_addr and host_wdata combinationally.
- R8: While fill_busy is high, host writes never reach the memory. In WAIT_FRAME and FINISH, cm_we stays low. In SWEEP, the port carries only sweep words.
- R9: If ctl_blk_en falls in WAIT_FRAME, the block writes nothing, pulses trig_clear for one cycle and returns to IDLE.
- R10: frame_sync pulses during a sweep do not restart or disturb the address walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_blk_en | input | 1 | Control bit permitting block fill |
| ctl_blk_go | input | 1 | Control bit starting a fill |
| ctl_pattern | input | PAT_W | Control field copied into word bits 15..13 |
| frame_sync | input | 1 | One-cycle frame-boundary strobe |
| host_we | input | 1 | Host write enable to connection memory |
| host_addr | input | ADDR_W | Host write address |
| host_wdata | input | WORD_W | Host write data |
| cm_we | output | 1 | Connection memory write enable |
| cm_addr | output | ADDR_W | Connection memory write address |
| cm_wdata | output | WORD_W | Connection memory write data |
| trig_clear | output | 1 | One-cycle request to clear ctl_blk_go |
| fill_busy | output | 1 | Fill armed or in progress |
| fill_done | output | 1 | One-cycle pulse when a fill completes |

## Verification
The bench keeps host writes active during the wait, the sweep and the finish cycle. A design that leaked host traffic into the memory would show a foreign address or word on the port. The pattern is changed right after the launching boundary. A design that did not hold the pattern would write a mixed fill. A stray frame strobe is driven mid-sweep, where a design that restarted on it would repeat low addresses. The bench also covers a start with the enable low and an enable that falls while the block is waiting. In both cases, a design that wrote anything, or forgot to clear the start bit, would leave the memory or the register wrong.

// File: rtl/cmbi_pkg.sv
package cmbi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REJECT,
        ST_WAIT,
        ST_SWEEP,
        ST_FINISH
    } cmbi_state_e;
endpackage

// File: rtl/cmbi_sweep_ctr.sv
module cmbi_sweep_ctr #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    logic [ADDR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + 1'b1;
        else          cnt_q <= '0;
    end

    assign addr = cnt_q;
    assign last = (cnt_q == {ADDR_W{1'b1}});
endmodule

// File: rtl/cmbi_fsm.sv
module cmbi_fsm
    import cmbi_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        blk_en,
    input  logic        blk_go,
    input  logic        frame_sync,
    input  logic        last,
    output cmbi_state_e state,
    output logic        run,
    output logic        load_pat,
    output logic        go_clear,
    output logic        done,
    output logic        busy
);
    cmbi_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (blk_go && blk_en)  state_d = ST_WAIT;   // arm
                else if (blk_go)       state_d = ST_REJECT; // refuse
            end
            ST_REJECT: state_d = ST_IDLE;                    // retire
            ST_WAIT: begin
                if (!blk_en)           state_d = ST_REJECT; // abort
                else if (frame_sync)   state_d = ST_SWEEP;  // launch
            end
            ST_SWEEP: begin
                if (last)              state_d = ST_FINISH; // last_word
            end
            ST_FINISH: state_d = ST_IDLE;                    // retire
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        run      = 1'b0;
        load_pat = 1'b0;
        go_clear = 1'b0;
        done     = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_REJECT: go_clear = 1'b1;
            ST_WAIT: begin
                busy     = 1'b1;
                load_pat = blk_en && frame_sync;
            end
            ST_SWEEP: begin
                busy = 1'b1;
                run  = 1'b1;
            end
            ST_FINISH: begin
                busy     = 1'b1;
                go_clear = 1'b1;
                done     = 1'b1;
            end
            default: ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/cmbi_wport.sv
module cmbi_wport #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 16,
    parameter int PAT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_pat,
    input  logic [PAT_W-1:0]  pattern_in,
    input  logic              sweep_active,
    input  logic              busy,
    input  logic [ADDR_W-1:0] sweep_addr,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic              cm_we,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [WORD_W-1:0] cm_wdata
);
    localparam int ZERO_W = WORD_W - PAT_W;

    logic [PAT_W-1:0]  pat_q;
    logic [WORD_W-1:0] fill_word;

    always_ff @(posedge clk) begin
        if (!rst_n)        pat_q <= '0;
        else if (load_pat) pat_q <= pattern_in;
    end

    assign fill_word = {pat_q, {ZERO_W{1'b0}}};

    always_comb begin
        if (sweep_active) begin
            cm_we    = 1'b1;
            cm_addr  = sweep_addr;
            cm_wdata = fill_word;
        end else begin
            cm_we    = host_we && !busy;
            cm_addr  = host_addr;
            cm_wdata = host_wdata;
        end
    end
endmodule

// File: rtl/cm_block_init.sv
module cm_block_init
    import cmbi_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int WORD_W       = 16,
    parameter int PAT_W        = 3,
    parameter int FRAME_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_blk_en,
    input  logic              ctl_blk_go,
    input  logic [PAT_W-1:0]  ctl_pattern,
    input  logic              frame_sync,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic              cm_we,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [WORD_W-1:0] cm_wdata,
    output logic              trig_clear,
    output logic              fill_busy,
    output logic              fill_done
);
    cmbi_state_e       cur_state;
    logic              sweep_run;
    logic              sweep_last;
    logic              pat_load;
    logic [ADDR_W-1:0] sweep_addr;

    cmbi_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_en     (ctl_blk_en),
        .blk_go     (ctl_blk_go),
        .frame_sync (frame_sync),
        .last       (sweep_last),
        .state      (cur_state),
        .run        (sweep_run),
        .load_pat   (pat_load),
        .go_clear   (trig_clear),
        .done       (fill_done),
        .busy       (fill_busy)
    );

    cmbi_sweep_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sweep_run),
        .addr  (sweep_addr),
        .last  (sweep_last)
    );

    cmbi_wport #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PAT_W(PAT_W)) u_wport (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_pat     (pat_load),
        .pattern_in   (ctl_pattern),
        .sweep_active (sweep_run),
        .busy         (fill_busy),
        .sweep_addr   (sweep_addr),
        .host_we      (host_we),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .cm_we        (cm_we),
        .cm_addr      (cm_addr),
        .cm_wdata     (cm_wdata)
    );
endmodule

// File: rtl/cmbi_checker.sv
module cmbi_checker
    import cmbi_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int WORD_W       = 16,
    parameter int PAT_W        = 3,
    parameter int FRAME_CYCLES = 40
) (
    input logic              clk,
    input logic              rst_n,
    input cmbi_state_e       state,
    input logic              cm_we,
    input logic [ADDR_W-1:0] cm_addr,
    input logic [WORD_W-1:0] cm_wdata,
    input logic              trig_clear,
    input logic              fill_busy,
    input logic              fill_done
);
    localparam int LIMIT = 2 * FRAME_CYCLES;
    localparam int CW    = $clog2(LIMIT + 2) + 1;
    localparam int ZW    = WORD_W - PAT_W;

    logic [CW-1:0] fill_cyc;

    always_ff @(posedge clk) begin
        if (!rst_n)                                      fill_cyc <= '0;
        else if (state == ST_SWEEP || state == ST_FINISH) fill_cyc <= fill_cyc + 1'b1;
        else                                             fill_cyc <= '0;
    end

    p_first_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWEEP && $past(state) == ST_WAIT) |-> (cm_we && cm_addr == '0));

    p_ascend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWEEP && $past(state) == ST_SWEEP) |-> (cm_addr == $past(cm_addr) + 1'b1));

    p_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWEEP) |-> (cm_wdata[ZW-1:0] == '0));

    p_clear_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trig_clear |=> !trig_clear);

    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> !fill_busy);

    p_two_frames_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cyc <= CW'(LIMIT));

    p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REJECT) |-> (trig_clear && !fill_busy && !fill_done));

    p_wait_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT || state == ST_FINISH) |-> !cm_we);
endmodule

bind cm_block_init cmbi_checker #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .PAT_W(PAT_W), .FRAME_CYCLES(FRAME_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (cur_state),
    .cm_we      (cm_we),
    .cm_addr    (cm_addr),
    .cm_wdata   (cm_wdata),
    .trig_clear (trig_clear),
    .fill_busy  (fill_busy),
    .fill_done  (fill_done)
);

// File: tb/tb_cm_block_init.sv
`timescale 1ns/1ps
module tb_cm_block_init;
    localparam int ADDR_W = 6;
    localparam int WORD_W = 16;
    localparam int PAT_W  = 3;
    localparam int FRAME  = 40;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctl_blk_en = 1'b0;
    logic              ctl_blk_go = 1'b0;
    logic [PAT_W-1:0]  ctl_pattern = '0;
    logic              frame_sync = 1'b0;
    logic              host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [WORD_W-1:0] host_wdata = '0;
    logic              cm_we;
    logic [ADDR_W-1:0] cm_addr;
    logic [WORD_W-1:0] cm_wdata;
    logic              trig_clear, fill_busy, fill_done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cm_block_init #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PAT_W(PAT_W), .FRAME_CYCLES(FRAME)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_blk_en(ctl_blk_en), .ctl_blk_go(ctl_blk_go),
        .ctl_pattern(ctl_pattern), .frame_sync(frame_sync), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .cm_we(cm_we), .cm_addr(cm_addr),
        .cm_wdata(cm_wdata), .trig_clear(trig_clear), .fill_busy(fill_busy), .fill_done(fill_done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        step();
        check(!fill_busy, "R1 busy", fill_busy, 0);
        check(!fill_done, "R1 done", fill_done, 0);
        check(!trig_clear, "R1 trig_clear", trig_clear, 0);
        check(!cm_we, "R1 cm_we", cm_we, 0);
    endtask

    task automatic t_host_pass();
        host_we = 1'b1; host_addr = 6'd5; host_wdata = 16'hABCD;
        #1;
        check(cm_we == 1'b1, "R7 we", cm_we, 1);
        check(cm_addr == 6'd5, "R7 addr", cm_addr, 5);
        check(cm_wdata == 16'hABCD, "R7 data", cm_wdata, 16'hABCD);
        host_we = 1'b0;
        #1;
        check(cm_we == 1'b0, "R7 we low", cm_we, 0);
        step();
    endtask

    task automatic t_fill(input logic [PAT_W-1:0] pat, input int wait_cyc, input bit stray_sync);
        int cyc;
        ctl_blk_en = 1'b1; ctl_pattern = pat; ctl_blk_go = 1'b1;
        host_we = 1'b1; host_addr = 6'd9; host_wdata = 16'h1234;
        step();
        check(fill_busy == 1'b1, "R2 busy after arm", fill_busy, 1);
        check(cm_we == 1'b0, "R8 host blocked in wait", cm_we, 0);
        for (int w = 0; w < wait_cyc; w++) begin
            step();
            check(cm_we == 1'b0, "R2 no write before boundary", cm_we, 0);
        end
        frame_sync = 1'b1;
        step();
        frame_sync = 1'b0;
        ctl_pattern = ~pat;
        cyc = 1;
        for (int i = 0; i < DEPTH; i++) begin
            host_addr = ADDR_W'(i * 7 + 3);
            host_wdata = 16'h0FFF;
            frame_sync = stray_sync && (i == 10);
            #1;
            check(cm_we == 1'b1, "R3 we in sweep", cm_we, 1);
            check(cm_addr == ADDR_W'(i), "R3 R10 addr order", cm_addr, i);
            check(cm_wdata == {pat, 13'b0}, "R4 R8 word", cm_wdata, {pat, 13'b0});
            step();
            cyc++;
        end
        frame_sync = 1'b0;
        #1;
        check(trig_clear == 1'b1, "R5 trig_clear", trig_clear, 1);
        check(fill_done == 1'b1, "R5 done", fill_done, 1);
        check(cm_we == 1'b0, "R8 host blocked in finish", cm_we, 0);
        check(cyc <= 2 * FRAME, "R5 within two frames", cyc, 2 * FRAME);
        ctl_blk_go = 1'b0;
        host_we = 1'b0;
        step();
        check(!trig_clear && !fill_done, "R5 single pulse", {trig_clear, fill_done}, 0);
        check(!fill_busy, "R5 busy falls", fill_busy, 0);
    endtask

    task automatic t_reject();
        ctl_blk_en = 1'b0; ctl_blk_go = 1'b1;
        step();
        check(trig_clear == 1'b1, "R6 clear pulse", trig_clear, 1);
        check(!fill_busy, "R6 busy low", fill_busy, 0);
        check(!cm_we, "R6 no write", cm_we, 0);
        ctl_blk_go = 1'b0;
        step();
        check(!trig_clear, "R6 pulse one cycle", trig_clear, 0);
        frame_sync = 1'b1;
        step();
        frame_sync = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check(!cm_we && !fill_busy, "R6 stays idle", {cm_we, fill_busy}, 0);
            step();
        end
    endtask

    task automatic t_abort();
        ctl_blk_en = 1'b1; ctl_blk_go = 1'b1;
        step();
        check(fill_busy == 1'b1, "R9 armed", fill_busy, 1);
        ctl_blk_en = 1'b0;
        step();
        check(trig_clear == 1'b1, "R9 clear pulse", trig_clear, 1);
        check(!fill_busy, "R9 busy low", fill_busy, 0);
        ctl_blk_go = 1'b0;
        step();
        frame_sync = 1'b1;
        step();
        frame_sync = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check(!cm_we && !trig_clear, "R9 no writes", {cm_we, trig_clear}, 0);
            step();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_host_pass();
        t_fill(3'b101, 3, 1'b0);
        t_fill(3'b010, 0, 1'b1);
        t_fill(3'b111, 7, 1'b1);
        t_reject();
        t_abort();
        t_host_pass();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule